// File: doc/BRIEF.md
# Configuration Reboot Command Sequencer

This block walks a configuration port through the fixed script of 16-bit words that makes the device reload its bitstream from a chosen flash location. A one-cycle start pulse latches a 24-bit primary (multiboot) address, a 24-bit fallback address and one 8-bit opcode for each of them. The block then presents the script one word at a time on a word output, qualified by a valid strobe. A word is held until the stall input is low at a clock edge. After that the next word appears.

The script has three parts. It opens with a dummy word and the two synchronisation words. It then writes four general registers, each with its own type-1 write header followed by one data word. It finishes with a command-register header, the reboot command and one no-operation word. The headers are formed from a type field, a write opcode, a register number and a word count. A parameter selects whether each output byte is sent bit-reversed, because some ports expect that order. Busy covers the whole script, and done pulses once when the script ends.

Top module: `cfg_reboot_seq`

## Requirements
- R1: After reset, valid_o, busy_o and done_o are all low.
- R2: A start_i pulse while idle makes valid_o and busy_o rise in the next cycle. The first three words are 0xFFFF, 0xAA99 and 0x5566, in that order.
- R3: Each header word is {3'b001, 2'b10 (write), 6-bit register number, 5-bit count = 1}. The four general-register headers are 0x3261, 0x3281, 0x32A1 and 0x32C1 (registers 0x13 to 0x16), and they are sent in that order.
- R4: Each general-register header is followed by one data word. After 0x3261 comes primary address [15:0]. After 0x3281 comes {primary opcode, primary address [23:16]}. After 0x32A1 comes fallback address [15:0]. After 0x32C1 comes {fallback opcode, fallback address [23:16]}. In each packed word the opcode occupies bits [15:8].
- R5: The script ends with 0x30A1 (register 0x05), then 0x000E, then 0x2000. The script is 14 words long.
- R6: While valid_o is high and stall_i is high at a clock edge, word_o and valid_o do not change in the next cycle.
- R7: With REVERSE_BITS = 1, output bit 8k+i carries script bit 8k+7-i within each byte k. With REVERSE_BITS = 0, the word is driven unchanged.
- R8: Addresses and opcodes are latched at the accepted start. Input changes during the script do not alter the words that are sent.
- R9: A start_i pulse while busy_o is high is ignored: the script neither restarts nor skips a word.
- R10: In the cycle after the final word is accepted, done_o is high for exactly one cycle, and valid_o and busy_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Start pulse; sampled only while idle |
| mb_addr_i | input | 24 | Primary reload address |
| fb_addr_i | input | 24 | Fallback reload address |
| mb_op_i | input | 8 | Opcode byte packed with the primary address high byte |
| fb_op_i | input | 8 | Opcode byte packed with the fallback address high byte |
| stall_i | input | 1 | Port not ready; the current word is held |
| word_o | output | 16 | Current script word, after the optional byte bit reversal |
| valid_o | output | 1 | Strobe qualifying word_o for the whole script |
| busy_o | output | 1 | Script in progress |
| done_o | output | 1 | One-cycle pulse after the last word is accepted |

## Verification
The assertions assume that the port holds stall_i stable across each clock edge. They also assume that start_i is a synchronous one-cycle signal, so a rising valid strobe can be traced to the start sample one cycle earlier. The stimulus changes every input one time unit after a rising edge. Stall patterns include none, pseudo-random and mostly-high. Extra start pulses and input changes are injected only while a script is running, and this exercises the requirements that such stimulus is ignored and that the inputs are latched at start.

// File: rtl/cfg_reboot_pkg.sv
package cfg_reboot_pkg;

  localparam int WORD_W = 16;

  typedef enum logic [3:0] {
    ST_DUMMY, ST_SYNC0, ST_SYNC1,
    ST_G1_HDR, ST_G1_DAT, ST_G2_HDR, ST_G2_DAT,
    ST_G3_HDR, ST_G3_DAT, ST_G4_HDR, ST_G4_DAT,
    ST_CMD_HDR, ST_CMD_DAT, ST_NOOP
  } step_e;

  localparam logic [5:0] REG_CMD  = 6'h05;
  localparam logic [5:0] REG_GEN1 = 6'h13;
  localparam logic [5:0] REG_GEN2 = 6'h14;
  localparam logic [5:0] REG_GEN3 = 6'h15;
  localparam logic [5:0] REG_GEN4 = 6'h16;

  localparam logic [WORD_W-1:0] W_DUMMY  = 16'hFFFF;
  localparam logic [WORD_W-1:0] W_SYNC0  = 16'hAA99;
  localparam logic [WORD_W-1:0] W_SYNC1  = 16'h5566;
  localparam logic [WORD_W-1:0] W_REBOOT = 16'h000E;
  localparam logic [WORD_W-1:0] W_NOOP   = 16'h2000;

  // type-1 write header carrying one word
  function automatic logic [WORD_W-1:0] wr_hdr(input logic [5:0] reg_num);
    return {3'b001, 2'b10, reg_num, 5'd1};
  endfunction

  function automatic logic [WORD_W-1:0] flip_bytes(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < WORD_W; i++) r[(i/8)*8 + 7 - (i%8)] = w[i];
    return r;
  endfunction

endpackage

// File: rtl/reboot_seq_ctrl.sv
module reboot_seq_ctrl
  import cfg_reboot_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  logic  stall,
  output step_e step,
  output logic  valid,
  output logic  done,
  output logic  accept
);
  step_e step_q, step_n;
  logic  valid_q, valid_n, done_q, done_n;

  always_comb begin
    step_n  = step_q;
    valid_n = valid_q;
    done_n  = 1'b0;
    accept  = 1'b0;
    if (!valid_q) begin
      if (start) begin
        accept  = 1'b1;
        valid_n = 1'b1;
        step_n  = ST_DUMMY;
      end
    end else if (!stall) begin
      if (step_q == ST_NOOP) begin
        valid_n = 1'b0;
        done_n  = 1'b1;
      end else begin
        step_n = step_e'(step_q + 4'd1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q  <= ST_DUMMY;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      step_q  <= step_n;
      valid_q <= valid_n;
      done_q  <= done_n;
    end
  end

  assign step  = step_q;
  assign valid = valid_q;
  assign done  = done_q;
endmodule

// File: rtl/reboot_word_gen.sv
module reboot_word_gen
  import cfg_reboot_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int OP_W   = 8
) (
  input  step_e                step,
  input  logic [ADDR_W-1:0]    mb_addr,
  input  logic [ADDR_W-1:0]    fb_addr,
  input  logic [OP_W-1:0]      mb_op,
  input  logic [OP_W-1:0]      fb_op,
  output logic [WORD_W-1:0]    word
);
  localparam int LO_W = WORD_W;
  localparam int HI_W = ADDR_W - LO_W;

  always_comb begin
    unique case (step)
      ST_DUMMY:   word = W_DUMMY;
      ST_SYNC0:   word = W_SYNC0;
      ST_SYNC1:   word = W_SYNC1;
      ST_G1_HDR:  word = wr_hdr(REG_GEN1);
      ST_G1_DAT:  word = mb_addr[LO_W-1:0];
      ST_G2_HDR:  word = wr_hdr(REG_GEN2);
      ST_G2_DAT:  word = {mb_op, mb_addr[ADDR_W-1 -: HI_W]};
      ST_G3_HDR:  word = wr_hdr(REG_GEN3);
      ST_G3_DAT:  word = fb_addr[LO_W-1:0];
      ST_G4_HDR:  word = wr_hdr(REG_GEN4);
      ST_G4_DAT:  word = {fb_op, fb_addr[ADDR_W-1 -: HI_W]};
      ST_CMD_HDR: word = wr_hdr(REG_CMD);
      ST_CMD_DAT: word = W_REBOOT;
      ST_NOOP:    word = W_NOOP;
      default:    word = W_NOOP;
    endcase
  end
endmodule

// File: rtl/reboot_bit_order.sv
module reboot_bit_order #(
  parameter int WORD_W       = 16,
  parameter bit REVERSE_BITS = 1'b1
) (
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout
);
  localparam int BYTES = WORD_W / 8;

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    for (genvar i = 0; i < 8; i++) begin : g_bit
      if (REVERSE_BITS) begin : g_rev
        assign dout[b*8 + i] = din[b*8 + 7 - i];
      end else begin : g_keep
        assign dout[b*8 + i] = din[b*8 + i];
      end
    end
  end
endmodule

// File: rtl/cfg_reboot_seq.sv
module cfg_reboot_seq
  import cfg_reboot_pkg::*;
#(
  parameter int ADDR_W       = 24,
  parameter int OP_W         = 8,
  parameter bit REVERSE_BITS = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] mb_addr_i,
  input  logic [ADDR_W-1:0] fb_addr_i,
  input  logic [OP_W-1:0]   mb_op_i,
  input  logic [OP_W-1:0]   fb_op_i,
  input  logic              stall_i,
  output logic [15:0]       word_o,
  output logic              valid_o,
  output logic              busy_o,
  output logic              done_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              accept;
  step_e             step;
  logic [WORD_W-1:0] raw_word;
  logic [ADDR_W-1:0] mb_addr_q, fb_addr_q;
  logic [OP_W-1:0]   mb_op_q, fb_op_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // operands latched only when a start is accepted
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mb_addr_q <= '0;
      fb_addr_q <= '0;
      mb_op_q   <= '0;
      fb_op_q   <= '0;
    end else if (accept) begin
      mb_addr_q <= mb_addr_i;
      fb_addr_q <= fb_addr_i;
      mb_op_q   <= mb_op_i;
      fb_op_q   <= fb_op_i;
    end
  end

  reboot_seq_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .start  (start_i),
    .stall  (stall_i),
    .step   (step),
    .valid  (valid_o),
    .done   (done_o),
    .accept (accept)
  );

  reboot_word_gen #(.ADDR_W(ADDR_W), .OP_W(OP_W)) u_gen (
    .step    (step),
    .mb_addr (mb_addr_q),
    .fb_addr (fb_addr_q),
    .mb_op   (mb_op_q),
    .fb_op   (fb_op_q),
    .word    (raw_word)
  );

  reboot_bit_order #(.WORD_W(WORD_W), .REVERSE_BITS(REVERSE_BITS)) u_order (
    .din  (raw_word),
    .dout (word_o)
  );

  assign busy_o = valid_o;
endmodule

// File: rtl/cfg_reboot_seq_chk.sv
module cfg_reboot_seq_chk
  import cfg_reboot_pkg::*;
#(
  parameter bit REVERSE_BITS = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        stall_i,
  input logic [15:0] word_o,
  input logic        valid_o,
  input logic        busy_o,
  input logic        done_o
);
  localparam logic [15:0] LAST_OUT = REVERSE_BITS ? flip_bytes(W_NOOP) : W_NOOP;

  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !valid_o && !busy_o);

  assert_first_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> $past(start_i) && word_o == W_DUMMY);

  assert_hold_on_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && stall_i |=> valid_o && $stable(word_o));

  assert_last_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(word_o) == LAST_OUT);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(valid_o && !stall_i));
endmodule

bind cfg_reboot_seq cfg_reboot_seq_chk #(.REVERSE_BITS(REVERSE_BITS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .stall_i (stall_i),
  .word_o  (word_o),
  .valid_o (valid_o),
  .busy_o  (busy_o),
  .done_o  (done_o)
);

// File: tb/test_cfg_reboot_seq.sv
module test_cfg_reboot_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] mb = '0, fb = '0;
  logic [7:0]  om = '0, of = '0;
  logic        stall = 1'b0;
  logic [15:0] word_a, word_b;
  logic        valid_a, busy_a, done_a, valid_b, busy_b, done_b;

  int checks = 0;
  int fails  = 0;
  int stall_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic [15:0] expq[$];
  string       tagq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_reboot_seq #(.REVERSE_BITS(1'b1)) i_cfg_reboot_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mb_addr_i(mb), .fb_addr_i(fb),
    .mb_op_i(om), .fb_op_i(of), .stall_i(stall), .word_o(word_a),
    .valid_o(valid_a), .busy_o(busy_a), .done_o(done_a));

  cfg_reboot_seq #(.REVERSE_BITS(1'b0)) i_cfg_reboot_seq_plain (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mb_addr_i(mb), .fb_addr_i(fb),
    .mb_op_i(om), .fb_op_i(of), .stall_i(stall), .word_o(word_b),
    .valid_o(valid_b), .busy_o(busy_b), .done_o(done_b));

  function automatic logic [15:0] rev8(input logic [15:0] w);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[(i/8)*8 + 7 - (i%8)] = w[i];
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // stall generator
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (stall_mode)
      0: stall = 1'b0;
      1: stall = lfsr[0];
      default: stall = (lfsr[1:0] != 2'b00);
    endcase
  end

  // monitor / scoreboard
  bit          exp_done = 0, done_prev = 0, held = 0;
  logic [15:0] hold_word;
  always @(negedge clk) begin
    if (rst_n) begin
      if (exp_done) begin
        chk(done_a && !valid_a && !busy_a, "R10", {13'd0, done_a, valid_a, busy_a}, 16'h4);
        chk(done_b && !valid_b, "R10", {14'd0, done_b, valid_b}, 16'h2);
        exp_done = 0;
        done_prev = 1;
      end else if (done_prev) begin
        chk(!done_a && !done_b, "R10", {15'd0, done_a}, 16'h0);
        done_prev = 0;
      end else if (done_a) begin
        chk(1'b0, "R10", 16'h1, 16'h0);
      end
      if (valid_a && held)
        chk(word_a == hold_word, "R6", word_a, hold_word);
      held = valid_a && stall;
      hold_word = word_a;
      if (valid_a && !stall) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R9", word_a, 16'hxxxx);
        end else begin
          logic [15:0] e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          chk(word_b == e, t, word_b, e);
          chk(word_a == rev8(e), {t, "/R7"}, word_a, rev8(e));
          if (expq.size() == 0) exp_done = 1;
        end
      end
    end
  end

  task automatic push(input logic [15:0] w, input string t);
    expq.push_back(w);
    tagq.push_back(t);
  endtask

  task automatic run_seq(input logic [23:0] a_mb, input logic [23:0] a_fb,
                         input logic [7:0] a_om, input logic [7:0] a_of, input bit poke);
    push(16'hFFFF, "R2"); push(16'hAA99, "R2"); push(16'h5566, "R2");
    push(16'h3261, "R3"); push(a_mb[15:0], "R4");
    push(16'h3281, "R3"); push({a_om, a_mb[23:16]}, "R4");
    push(16'h32A1, "R3"); push(a_fb[15:0], "R4");
    push(16'h32C1, "R3"); push({a_of, a_fb[23:16]}, "R4");
    push(16'h30A1, "R5"); push(16'h000E, "R5"); push(16'h2000, "R5");
    @(posedge clk); #1;
    mb = a_mb; fb = a_fb; om = a_om; of = a_of; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    @(negedge clk);
    chk(valid_a && busy_a, "R2", {14'd0, valid_a, busy_a}, 16'h3);
    if (poke) begin
      repeat (3) @(posedge clk);
      #1;
      mb = ~a_mb; fb = ~a_fb; om = ~a_om; of = ~a_of;   // R8
      start = 1'b1;                                     // R9
      @(posedge clk); #1;
      start = 1'b0;
    end
    while (!done_a) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(expq.size() == 0, "R5", 16'(expq.size()), 16'h0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!valid_a && !busy_a && !done_a, "R1", {13'd0, valid_a, busy_a, done_a}, 16'h0);
    chk(!valid_b && !busy_b && !done_b, "R1", {13'd0, valid_b, busy_b, done_b}, 16'h0);
    stall_mode = 0; run_seq(24'h123456, 24'hABCDEF, 8'h03, 8'h0B, 1'b0);
    stall_mode = 1; run_seq(24'h9A5C01, 24'h00F00F, 8'h6B, 8'hC4, 1'b1);
    stall_mode = 2; run_seq(24'hFFFFFF, 24'h000000, 8'h80, 8'h01, 1'b1);
    stall_mode = 1; run_seq(24'h010203, 24'h405060, 8'hE7, 8'h18, 1'b0);
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule